// File: doc/BRIEF.md
# Time-Base Timer and Watchdog Unit

The unit keeps a free-running 64-bit time base that advances by one on every clock cycle in which the tick enable is high. Three timers are driven from this shared count.

The first is a 32-bit programmable interval timer that counts down to zero and can reload itself. The second is a fixed-interval timer that raises an interrupt when a selected time-base bit rises from 0 to 1. The third is a watchdog that uses the same rising-bit detection but issues a one-cycle reset request carrying a software-chosen reset kind, in place of an interrupt.

Software reaches the unit through a small synchronous register port. A write takes effect at the clock edge on which the write strobe is high. Reads are combinational from the read address.

Register addresses are:

| Address | Contents |
|---------|----------|
| 0 | time base, low half |
| 1 | time base, high half |
| 2 | interval count |
| 3 | reload value |
| 4 | control |
| 5 | status |

The control register holds these fields:

| Bits | Field |
|------|-------|
| [0] | interval enable |
| [1] | auto-reload |
| [2] | fixed-interval enable |
| [3] | watchdog enable |
| [5:4] | fixed-interval tap select |
| [7:6] | watchdog tap select |
| [9:8] | reset kind |

The status register holds these flags:

| Bit | Flag |
|-----|------|
| [0] | interval flag |
| [1] | fixed-interval flag |

Top module: `tbtimer_top`

## Requirements
- R1: With tick_en high the 64-bit time base increases by exactly one per clock, carrying from the low half (address 0) into the high half (address 1). With tick_en low it holds its value.
- R2: A write to address 0 or address 1 replaces that half of the time base on the write edge. The write takes precedence over the increment on that edge.
- R3: With the interval enable (control bit 0) and tick_en both high, the count at address 2 drops by one per clock. Without auto-reload the count stops at zero and stays there.
- R4: When the count steps from 1 to 0, status bit 0 and irq_pit go high on that same edge. Writing a count of zero never sets the flag.
- R5: With auto-reload (control bit 1) set, the count takes the reload value (address 3) on the edge after it reached zero. Decrementing then resumes from that value.
- R6: The fixed-interval tap is chosen by control bits [5:4]: 00 selects bit 9, 01 selects bit 13, 10 selects bit 17 and 11 selects bit 21. When the tapped bit rises with control bit 2 set, status bit 1 and irq_fit go high one clock after the rise is visible. The flag is not set while the enable is clear.
- R7: A rise of a tapped bit caused by a software write of the time base, or appearing on the cycle after a control write, is not treated as an event.
- R8: Status flags are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A new event on the same edge as a clear wins.
- R9: With control bit 3 set, a rise of the watchdog tap (control bits [7:6], same encoding as R6) produces a one-cycle rst_req pulse one clock after the rise. During that pulse rst_kind carries control bits [9:8] (01 core, 10 chip, 11 system). Kind 00 produces no pulse, and rst_kind is 0 whenever rst_req is low.
- R10: After reset every register reads zero and irq_pit, irq_fit, rst_req and rst_kind are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| tick_en | input | 1 | advance time base and interval count this cycle |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register write address |
| wr_data | input | 32 | register write data |
| rd_addr | input | 3 | register read address |
| rd_data | output | 32 | register read data (combinational) |
| irq_pit | output | 1 | interval timer interrupt (level, sticky) |
| irq_fit | output | 1 | fixed-interval interrupt (level, sticky) |
| rst_req | output | 1 | one-cycle watchdog reset request |
| rst_kind | output | 2 | reset kind during rst_req, else 0 |

## Verification
A corrupted time base shows up at once on the address 0 and address 1 reads. On the next tapped-bit rise it also appears as an interrupt or reset pulse that arrives a cycle early, a cycle late, or not at all.

An interval count that has gone wrong reads back incorrectly on the following cycle. It then moves the edge on which irq_pit rises.

A stale edge-history bit or a missing load suppression produces a spurious irq_fit or rst_req within two clocks of a time-base write. The directed cases load the time base just below each tap boundary so that every rise can be timed to the exact edge.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    localparam int TB_W   = 64;
    localparam int PIT_W  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_TB_LO = 3'd0,
        RA_TB_HI = 3'd1,
        RA_COUNT = 3'd2,
        RA_RELOAD = 3'd3,
        RA_CTRL  = 3'd4,
        RA_FLAGS = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CORE = 2'd1,
        RK_CHIP = 2'd2,
        RK_SYS  = 2'd3
    } rst_kind_e;

    typedef struct packed {
        rst_kind_e  kind;
        logic [1:0] wdg_sel;
        logic [1:0] fit_sel;
        logic       wdg_en;
        logic       fit_en;
        logic       pit_auto;
        logic       pit_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic fit;
        logic pit;
    } flags_t;

    localparam int FLAGS_W = $bits(flags_t);

    function automatic int unsigned tap_pos(input logic [1:0] sel);
        case (sel)
            2'd0:    return 9;
            2'd1:    return 13;
            2'd2:    return 17;
            default: return 21;
        endcase
    endfunction

endpackage

// File: rtl/tbt_timebase.sv
module tbt_timebase
    import tbt_pkg::*;
#(
    parameter int W  = TB_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [DW-1:0] wdata,
    output logic [W-1:0]  value,
    output logic          loaded
);
    localparam int HI_W = W - DW;

    logic [W-1:0] nxt;

    always_comb begin
        nxt = value;
        if (tick) nxt = value + W'(1);
        if (ld_lo) nxt[DW-1:0] = wdata;
        if (ld_hi) nxt[W-1:DW] = wdata[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value  <= '0;
            loaded <= 1'b0;
        end else begin
            value  <= nxt;
            loaded <= ld_lo | ld_hi;
        end
    end

    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_lo && !ld_hi) |=> value == $past(value) + W'(1));

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld_lo && !ld_hi) |=> $stable(value));

endmodule

// File: rtl/tbt_interval.sv
module tbt_interval
    import tbt_pkg::*;
#(
    parameter int W = PIT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         en,
    input  logic         auto_rl,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         hit
);
    logic at_zero;

    assign at_zero = (count == '0);
    assign hit     = !ld && en && tick && (count == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (ld) begin
            count <= ld_val;
        end else if (en && auto_rl && at_zero) begin
            count <= reload;
        end else if (en && tick && !at_zero) begin
            count <= count - W'(1);
        end
    end

    assert_stop_R3: assert property (@(posedge clk) disable iff (rst)
        (at_zero && !ld && !auto_rl) |=> count == '0);

    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (at_zero && en && auto_rl && !ld) |=> count == $past(reload));

    assert_hit_zero_R4: assert property (@(posedge clk) disable iff (rst)
        hit |=> count == '0);

endmodule

// File: rtl/tbt_tap_edge.sv
module tbt_tap_edge
    import tbt_pkg::*;
#(
    parameter int W = TB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tb,
    input  logic [1:0]   sel,
    input  logic         quiet,
    output logic         evt
);
    logic tap;
    logic prev_q;

    assign tap = tb[tap_pos(sel)];
    assign evt = tap && !prev_q && !quiet;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= tap;
    end

    assert_single_evt_R6: assert property (@(posedge clk) disable iff (rst)
        (evt && $stable(sel)) |=> !evt);

endmodule

// File: rtl/tbtimer_top.sv
module tbtimer_top
    import tbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_pit,
    output logic              irq_fit,
    output logic              rst_req,
    output logic [1:0]        rst_kind
);
    ctrl_t              ctrl_q;
    flags_t             flags_q;
    logic [PIT_W-1:0]   reload_q;
    logic [TB_W-1:0]    tb;
    logic [PIT_W-1:0]   count;
    logic               tb_loaded;
    logic               ctrl_wr_q;
    logic               quiet;
    logic               pit_hit;
    logic               fit_evt;
    logic               wdg_evt;
    logic               rst_req_q;
    rst_kind_e          rst_kind_q;

    logic wr_tbl, wr_tbh, wr_cnt, wr_rld, wr_ctl, wr_flg;

    assign wr_tbl = wr_en && (wr_addr == RA_TB_LO);
    assign wr_tbh = wr_en && (wr_addr == RA_TB_HI);
    assign wr_cnt = wr_en && (wr_addr == RA_COUNT);
    assign wr_rld = wr_en && (wr_addr == RA_RELOAD);
    assign wr_ctl = wr_en && (wr_addr == RA_CTRL);
    assign wr_flg = wr_en && (wr_addr == RA_FLAGS);

    tbt_timebase #(.W(TB_W), .DW(DATA_W)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_en),
        .ld_lo  (wr_tbl),
        .ld_hi  (wr_tbh),
        .wdata  (wr_data),
        .value  (tb),
        .loaded (tb_loaded)
    );

    tbt_interval #(.W(PIT_W)) u_pit (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .en      (ctrl_q.pit_en),
        .auto_rl (ctrl_q.pit_auto),
        .ld      (wr_cnt),
        .ld_val  (wr_data[PIT_W-1:0]),
        .reload  (reload_q),
        .count   (count),
        .hit     (pit_hit)
    );

    assign quiet = tb_loaded || ctrl_wr_q;

    tbt_tap_edge #(.W(TB_W)) u_fit_edge (
        .clk   (clk),
        .rst   (rst),
        .tb    (tb),
        .sel   (ctrl_q.fit_sel),
        .quiet (quiet),
        .evt   (fit_evt)
    );

    tbt_tap_edge #(.W(TB_W)) u_wdg_edge (
        .clk   (clk),
        .rst   (rst),
        .tb    (tb),
        .sel   (ctrl_q.wdg_sel),
        .quiet (quiet),
        .evt   (wdg_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            reload_q  <= '0;
            ctrl_wr_q <= 1'b0;
        end else begin
            ctrl_wr_q <= wr_ctl;
            if (wr_ctl) ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_rld) reload_q <= wr_data[PIT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.pit <= (flags_q.pit && !(wr_flg && wr_data[0])) || pit_hit;
            flags_q.fit <= (flags_q.fit && !(wr_flg && wr_data[1]))
                           || (fit_evt && ctrl_q.fit_en);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_q  <= 1'b0;
            rst_kind_q <= RK_NONE;
        end else if (wdg_evt && ctrl_q.wdg_en && (ctrl_q.kind != RK_NONE)) begin
            rst_req_q  <= 1'b1;
            rst_kind_q <= ctrl_q.kind;
        end else begin
            rst_req_q  <= 1'b0;
            rst_kind_q <= RK_NONE;
        end
    end

    always_comb begin
        case (rd_addr)
            RA_TB_LO:  rd_data = tb[DATA_W-1:0];
            RA_TB_HI:  rd_data = tb[TB_W-1:DATA_W];
            RA_COUNT:  rd_data = DATA_W'(count);
            RA_RELOAD: rd_data = DATA_W'(reload_q);
            RA_CTRL:   rd_data = DATA_W'(ctrl_q);
            RA_FLAGS:  rd_data = DATA_W'(flags_q);
            default:   rd_data = '0;
        endcase
    end

    assign irq_pit  = flags_q.pit;
    assign irq_fit  = flags_q.fit;
    assign rst_req  = rst_req_q;
    assign rst_kind = rst_kind_q;

    assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_rst_kind_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> rst_kind != 2'd0);

    assert_kind_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !rst_req |-> rst_kind == 2'd0);

    assert_pit_flag_zero_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pit) |-> count == '0);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_flg && wr_data[1] && !fit_evt) |=> !irq_fit);

    assert_quiet_load_R7: assert property (@(posedge clk) disable iff (rst)
        tb_loaded |-> !fit_evt && !wdg_evt);

endmodule

// File: tb/tb_tbtimer_top.sv
module tb_tbtimer_top;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_pit, irq_fit, rst_req;
    logic [1:0]  rst_kind;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbtimer_top dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_pit(irq_pit), .irq_fit(irq_fit),
        .rst_req(rst_req), .rst_kind(rst_kind)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R10", "reg after reset", 64'(v), 64'h0);
        end
        chk("R10", "outputs after reset",
            {59'h0, irq_pit, irq_fit, rst_req, rst_kind}, 64'h0);
    endtask

    task automatic t_timebase();
        logic [31:0] lo, hi;
        wr(3'd0, 32'hFFFF_FFFE);
        tick_en = 1'b1;
        step(3);
        tick_en = 1'b0;
        rd(3'd0, lo); rd(3'd1, hi);
        chk("R1", "carry into high half", {hi, lo}, 64'h1_0000_0001);
        step(2);
        rd(3'd0, lo);
        chk("R1", "hold with tick low", 64'(lo), 64'h1);
        tick_en = 1'b1;
        wr(3'd0, 32'h10);
        rd(3'd0, lo);
        chk("R2", "load wins over increment", 64'(lo), 64'h10);
        step(1);
        rd(3'd0, lo);
        chk("R1", "increment after load", 64'(lo), 64'h11);
        wr(3'd1, 32'h0);
        rd(3'd1, hi);
        chk("R2", "high half load", 64'(hi), 64'h0);
    endtask

    task automatic t_pit_basic();
        logic [31:0] c;
        wr(3'd4, 32'h1);
        wr(3'd2, 32'd3);
        rd(3'd2, c);
        chk("R3", "count after load", 64'(c), 64'd3);
        step(2);
        rd(3'd2, c);
        chk("R3", "count after two ticks", 64'(c), 64'd1);
        chk("R4", "irq before zero", 64'(irq_pit), 64'd0);
        step(1);
        rd(3'd2, c);
        chk("R4", "count reaches zero", 64'(c), 64'd0);
        chk("R4", "irq at zero", 64'(irq_pit), 64'd1);
        step(3);
        rd(3'd2, c);
        chk("R3", "stays at zero", 64'(c), 64'd0);
        chk("R8", "flag sticky", 64'(irq_pit), 64'd1);
        wr(3'd5, 32'h0);
        chk("R8", "write 0 keeps flag", 64'(irq_pit), 64'd1);
        wr(3'd5, 32'h1);
        chk("R8", "write 1 clears flag", 64'(irq_pit), 64'd0);
        wr(3'd2, 32'd0);
        step(3);
        chk("R4", "zero load no irq", 64'(irq_pit), 64'd0);
    endtask

    task automatic t_pit_auto();
        logic [31:0] c;
        wr(3'd3, 32'd5);
        wr(3'd4, 32'h3);
        wr(3'd2, 32'd2);
        step(2);
        rd(3'd2, c);
        chk("R5", "zero before reload", 64'(c), 64'd0);
        chk("R4", "irq with auto", 64'(irq_pit), 64'd1);
        step(1);
        rd(3'd2, c);
        chk("R5", "reloaded value", 64'(c), 64'd5);
        step(1);
        rd(3'd2, c);
        chk("R5", "counts after reload", 64'(c), 64'd4);
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h3);
    endtask

    task automatic t_fit();
        logic [31:0] f;
        wr(3'd4, 32'h4);
        wr(3'd5, 32'h3);
        wr(3'd0, 32'h1FE);
        step(2);
        chk("R6", "no irq before visible rise", 64'(irq_fit), 64'd0);
        step(1);
        chk("R6", "bit 9 rise irq", 64'(irq_fit), 64'd1);
        wr(3'd4, 32'h34);
        wr(3'd5, 32'h2);
        chk("R8", "fit flag cleared", 64'(irq_fit), 64'd0);
        wr(3'd0, 32'h3FE);
        step(4);
        chk("R6", "sel 11 ignores bit 9", 64'(irq_fit), 64'd0);
        wr(3'd0, 32'h1F_FFFE);
        step(2);
        chk("R6", "sel 11 before rise", 64'(irq_fit), 64'd0);
        step(1);
        chk("R6", "bit 21 rise irq", 64'(irq_fit), 64'd1);
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h2);
        wr(3'd0, 32'h1FE);
        step(4);
        rd(3'd5, f);
        chk("R6", "disabled no flag", 64'(f), 64'd0);
    endtask

    task automatic t_false_edge();
        tick_en = 1'b0;
        wr(3'd4, 32'h4);
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h3);
        step(2);
        wr(3'd0, 32'h200);
        step(3);
        chk("R7", "load causes no edge", 64'(irq_fit), 64'd0);
        wr(3'd4, 32'h0);
    endtask

    task automatic watch(input int n, output int pulses, output logic [1:0] k);
        pulses = 0; k = 2'd0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) begin pulses++; k = rst_kind; end
        end
    endtask

    task automatic t_wdg();
        int p;
        logic [1:0] k;
        tick_en = 1'b1;
        wr(3'd4, 32'h248);
        wr(3'd0, 32'h1FFE);
        step(2);
        chk("R9", "no request before rise", 64'(rst_req), 64'd0);
        step(1);
        chk("R9", "request on bit 13", 64'({rst_req, rst_kind}), 64'h6);
        step(1);
        chk("R9", "one-cycle pulse", 64'({rst_req, rst_kind}), 64'h0);
        wr(3'd4, 32'h048);
        wr(3'd0, 32'h1FFE);
        watch(5, p, k);
        chk("R9", "kind 00 no request", 64'(p), 64'd0);
        wr(3'd4, 32'h308);
        wr(3'd0, 32'h1FE);
        watch(5, p, k);
        chk("R9", "sel 00 system pulse count", 64'(p), 64'd1);
        chk("R9", "sel 00 system kind", 64'(k), 64'd3);
        wr(3'd4, 32'h0);
        tick_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_timebase();
        tick_en = 1'b1;
        t_pit_basic();
        t_pit_auto();
        t_fit();
        t_false_edge();
        t_wdg();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule